// File: doc/BRIEF.md
# PHY Management Register Access Unit

This unit gives host software a single 32-bit command register for reaching a bank of 32 sixteen-bit PHY management registers held inside the block. Software writes a command word carrying a PHY address, a register index, an opcode and a 16-bit data value. On the clock edge that takes the write, the unit screens the command against a fixed PHY address and a per-index capability table, then performs the read or write. It stores the outcome, with ready and error flags, back into the command register.

Every command, including a rejected one, sets the management-done cause bit in an interrupt cause register. An interrupt request is driven while any cause bit is enabled by the mask register. Reading the cause register returns its value and then clears it. Host access is a simple select-addressed bus: select 0 is the command register, select 1 is the cause register (reading it clears it), select 2 is the mask register, and select 3 reads as zero.

Top module: `mdio_cmd_unit`

## Requirements
- R1: After reset, the command, cause and mask registers read zero and `irq` is low. PHY index 2 holds `ID_HI` (default 0x0141) and index 3 holds `ID_LO` (default 0x0C20).
- R2: If a command's PHY address field (bits 25:21) differs from `PHY_ADDR` (default 1), the command register keeps its previous bits 27:0, sets error (bit 30) and sets ready (bit 28). No PHY register changes.
- R3: Capability by index. Indices 0, 4, 9, 16 and 20 are read-write. Indices 1, 2, 3, 5, 10 and 21 are read-only. Every other index has no access.
- R4: Bit 27 set selects a read, and it takes precedence over bit 26. A permitted read replaces bits 15:0 with the register value and keeps every other written bit.
- R5: A read of an index without read capability sets error and keeps the written data field.
- R6: A command with bit 26 set and bit 27 clear is a write. A permitted write stores bits 15:0 into the indexed register.
- R7: A write to an index without write capability sets error and leaves the stored register unchanged.
- R8: One clock after any command write, the command register shows ready (bit 28). Cause bit 9 (management done) and cause bit 31 (summary) are both set.
- R9: `irq` is high exactly when the bitwise AND of the cause and mask registers is nonzero.
- R10: A cause register read returns the current value, and the cause register is zero afterwards.
- R11: A command whose opcode bits 27:26 are 00 is stored as written with ready set. No PHY register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe (used to clear the cause register) |
| host_sel | input | 2 | Register select: 0 command, 1 cause, 2 mask |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default parameters, so the PHY address is 1 and the identifier constants are known. Identifier reads can therefore be checked against fixed values. About three quarters of the random commands target the valid PHY address, so the capability table is exercised across all 32 indices and all four opcodes. The rest probe address rejection. Mask writes and clearing cause reads are interleaved so that the interrupt output is seen rising and falling.

// File: rtl/mdio_cmd_unit.sv
module mdio_cmd_unit #(
  parameter logic [4:0]  PHY_ADDR  = 5'd1,
  parameter logic [15:0] ID_HI     = 16'h0141,
  parameter logic [15:0] ID_LO     = 16'h0C20,
  parameter logic [15:0] CTRL_INIT = 16'h1140,
  parameter logic [15:0] STAT_INIT = 16'h796D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [1:0]  host_sel,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        irq
);
  localparam int RDY = 28;
  localparam int ERR = 30;
  localparam logic [31:0] DONE_CAUSE = 32'h8000_0200;
  localparam logic [1:0] SEL_CMD = 2'd0, SEL_CAUSE = 2'd1, SEL_MASK = 2'd2;

  function automatic logic [1:0] cap(input logic [4:0] i);
    case (i)
      5'd0, 5'd4, 5'd9, 5'd16, 5'd20:          cap = 2'b11;
      5'd1, 5'd2, 5'd3, 5'd5, 5'd10, 5'd21:    cap = 2'b01;
      default:                                 cap = 2'b00;
    endcase
  endfunction

  function automatic logic [15:0] init_val(input int i);
    case (i)
      0:       init_val = CTRL_INIT;
      1:       init_val = STAT_INIT;
      2:       init_val = ID_HI;
      3:       init_val = ID_LO;
      default: init_val = 16'h0000;
    endcase
  endfunction

  logic [31:0] cmd_q, cause_q, mask_q, cmd_nx;
  logic [15:0] phy [32];
  logic        phy_we;

  wire        cmd_wr    = host_wr && host_sel == SEL_CMD;
  wire        cause_clr = host_rd && host_sel == SEL_CAUSE;
  wire [4:0]  w_idx     = host_wdata[20:16];
  wire        addr_ok   = host_wdata[25:21] == PHY_ADDR;
  wire [1:0]  w_cap     = cap(w_idx);

  always_comb begin
    cmd_nx = host_wdata;
    phy_we = 1'b0;
    if (!addr_ok)
      cmd_nx = cmd_q | (32'd1 << ERR);
    else if (host_wdata[27]) begin
      if (!w_cap[0]) cmd_nx[ERR] = 1'b1;
      else           cmd_nx[15:0] = phy[w_idx];
    end else if (host_wdata[26]) begin
      if (!w_cap[1]) cmd_nx[ERR] = 1'b1;
      else           phy_we = 1'b1;
    end
    cmd_nx[RDY] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      cause_q <= '0;
      mask_q  <= '0;
      for (int i = 0; i < 32; i++) phy[i] <= init_val(i);
    end else begin
      if (cmd_wr) cmd_q <= cmd_nx;
      if (cmd_wr && phy_we) phy[w_idx] <= host_wdata[15:0];
      if (host_wr && host_sel == SEL_MASK) mask_q <= host_wdata;
      cause_q <= (cause_clr ? 32'd0 : cause_q) | (cmd_wr ? DONE_CAUSE : 32'd0);
    end
  end

  always_comb
    case (host_sel)
      SEL_CMD:   host_rdata = cmd_q;
      SEL_CAUSE: host_rdata = cause_q;
      SEL_MASK:  host_rdata = mask_q;
      default:   host_rdata = '0;
    endcase

  assign irq = |(cause_q & mask_q);

  a_r2_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !addr_ok |=> cmd_q[ERR] && cmd_q[RDY] && cmd_q[27:0] == $past(cmd_q[27:0]));
  a_r8_done: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> cmd_q[RDY] && cause_q[9] && cause_q[31]);
  a_r6_store: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && addr_ok && !host_wdata[27] && host_wdata[26] && w_cap[1]
      |=> phy[$past(w_idx)] == $past(host_wdata[15:0]));
  a_r7_ro_reject: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && addr_ok && !host_wdata[27] && host_wdata[26] && !w_cap[1] |=> cmd_q[ERR]);
  a_r9_no_cause_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q == 32'd0 |-> !irq);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cause_clr && !cmd_wr |=> cause_q == 32'd0);
endmodule

// File: tb/mdio_cmd_unit_tb.sv
module mdio_cmd_unit_tb;
  logic        clk = 0, rst_n = 0, host_wr = 0, host_rd = 0;
  logic [1:0]  host_sel = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic        irq;
  int n_cmp = 0, n_bad = 0;

  logic [15:0] mphy [32];
  logic [31:0] mcmd = 0, mcause = 0, mmask = 0;

  mdio_cmd_unit u_dut (.clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [1:0] mcap(input logic [4:0] i);
    if (i == 0 || i == 4 || i == 9 || i == 16 || i == 20) return 2'b11;
    if (i == 1 || i == 2 || i == 3 || i == 5 || i == 10 || i == 21) return 2'b01;
    return 2'b00;
  endfunction

  task automatic bus_wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); host_wr = 1; host_sel = s; host_wdata = d;
    @(posedge clk); #1; host_wr = 0;
  endtask

  task automatic bus_rd(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk); host_rd = 1; host_sel = s; #1 d = host_rdata;
    @(posedge clk); #1; host_rd = 0;
  endtask

  task automatic do_cmd(input string tag, input logic [31:0] v);
    logic [31:0] e, got;
    logic [4:0] ix = v[20:16];
    e = v;
    if (v[25:21] != 5'd1) e = mcmd | (32'd1 << 30);
    else if (v[27]) begin
      if (!mcap(ix)[0]) e[30] = 1'b1; else e[15:0] = mphy[ix];
    end else if (v[26]) begin
      if (!mcap(ix)[1]) e[30] = 1'b1; else mphy[ix] = v[15:0];
    end
    e[28] = 1'b1;
    mcmd = e;
    mcause = mcause | 32'h8000_0200;
    bus_wr(2'd0, v);
    bus_rd(2'd0, got);
    chk(tag, got, e);
    chk("R9 irq after command", {31'd0, irq}, {31'd0, |(mcause & mmask)});
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                     input logic [4:0] ix, input logic [15:0] d);
    return {4'd0, op, pa, ix, d};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog expired got=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) mphy[i] = 16'h0;
    mphy[0] = 16'h1140; mphy[1] = 16'h796D; mphy[2] = 16'h0141; mphy[3] = 16'h0C20;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    bus_rd(2'd0, r); chk("R1 cmd reset", r, 0);
    bus_rd(2'd2, r); chk("R1 mask reset", r, 0);
    bus_rd(2'd1, r); chk("R1 cause reset", r, 0);
    chk("R1 irq reset", {31'd0, irq}, 0);

    do_cmd("R1 R4 read id low", mk(2'b10, 5'd1, 5'd3, 16'hFFFF));
    do_cmd("R1 R4 read id high", mk(2'b10, 5'd1, 5'd2, 16'h1234));
    do_cmd("R4 read precedence op11", mk(2'b11, 5'd1, 5'd0, 16'hAAAA));
    do_cmd("R6 write rw idx 4", mk(2'b01, 5'd1, 5'd4, 16'hBEEF));
    do_cmd("R6 readback idx 4", mk(2'b10, 5'd1, 5'd4, 16'h0000));
    do_cmd("R7 write read-only idx 1", mk(2'b01, 5'd1, 5'd1, 16'h0000));
    do_cmd("R7 status unchanged", mk(2'b10, 5'd1, 5'd1, 16'h0000));
    do_cmd("R5 read no-cap idx 6", mk(2'b10, 5'd1, 5'd6, 16'h5A5A));
    do_cmd("R3 write no-cap idx 31", mk(2'b01, 5'd1, 5'd31, 16'h1111));
    do_cmd("R2 bad phy addr", mk(2'b01, 5'd2, 5'd4, 16'h0000));
    do_cmd("R2 addr check readback", mk(2'b10, 5'd1, 5'd4, 16'h0000));
    do_cmd("R11 no opcode", mk(2'b00, 5'd1, 5'd0, 16'hC0DE));

    bus_rd(2'd1, r); chk("R8 R10 cause value", r, mcause); mcause = 0;
    bus_rd(2'd1, r); chk("R10 cause cleared", r, 0);
    bus_wr(2'd2, 32'h0000_0200); mmask = 32'h0000_0200;
    chk("R9 irq low with empty cause", {31'd0, irq}, 0);
    do_cmd("R8 R9 irq rises", mk(2'b10, 5'd1, 5'd9, 16'h0));
    bus_rd(2'd1, r); chk("R10 cause read", r, mcause); mcause = 0;
    chk("R9 irq falls after clear", {31'd0, irq}, 0);

    for (int k = 0; k < 400; k++) begin
      logic [31:0] v = $urandom;
      v[25:21] = ($urandom % 4 == 0) ? 5'($urandom) : 5'd1;
      if ($urandom % 10 == 0) begin
        bus_wr(2'd2, v); mmask = v;
        chk("R9 irq after mask", {31'd0, irq}, {31'd0, |(mcause & mmask)});
      end else if ($urandom % 10 == 0) begin
        bus_rd(2'd1, r); chk("R10 random cause read", r, mcause); mcause = 0;
        chk("R9 irq after clear", {31'd0, irq}, 0);
      end else
        do_cmd("R3 random command", v);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule